// File: doc/BRIEF.md
# Fixed-Order Chained Rail Sequencer

This controller powers four supply rails up and down through external gate drivers in a fixed order. Channel A is bit 0 of every channel vector and channel D is bit 3. Channels turn on A, B, C, D and turn off D, C, B, A. There are no programmable per-channel delays. Each step waits for a feedback flag from the analog gate of the channel before it. A flag says the gate is nearly high, fully high, or below its low threshold. The analog gate ramps are outside this block; it only drives one enable bit per gate and reads back the flags.

The controller starts a power-up only after two conditions have held without a break for a qualification window: the active-low enable is low, and all four undervoltage-good flags are high. When the last gate is fully high, a hold counter runs. At the end of the hold, the active-low reset output is released. Each kind of failure has its own response:
- Loss of any undervoltage-good flag is a fault. All gates drop at once and both active-low reset outputs go low.
- A gate whose feedback does not arrive within a bounded number of cycles raises the same fault.
- Raising the enable starts an orderly shutdown in reverse order.

States and transitions:
- IDLE → QUAL when the enable is low and every undervoltage flag is good.
- QUAL → IDLE when either condition breaks.
- QUAL → ON_STEP when the window completes.
- ON_STEP → ON_STEP: move to the next channel when the current channel's near-high flag arrives.
- ON_STEP → RST_WAIT when the last channel's full-high flag arrives.
- RST_WAIT → RUN when the hold completes.
- ON_STEP, RST_WAIT or RUN → OFF_STEP when the enable rises.
- OFF_STEP → OFF_STEP: move to the next lower channel when the current channel's low flag arrives.
- OFF_STEP → IDLE when channel A's low flag arrives.
- ON_STEP, RST_WAIT, RUN or OFF_STEP → FAULT when an undervoltage flag drops.
- ON_STEP or OFF_STEP → FAULT when the step timeout expires.
- FAULT → IDLE when the enable is high.

Top module: `rail_chain_seq`

## Requirements
- R1: With en_n low and uv_ok all ones, gate_en stays 4'b0000 for QUAL_CYCLES rising edges after the first edge that sees both conditions. Gate A (bit 0) is enabled on the next edge after those QUAL_CYCLES edges. Any break in either condition restarts the window from zero.
- R2: Gates turn on in order A, B, C, D (bits 0 to 3). Gate k+1 is enabled on the edge that samples gate_near[k] high. The enabled set is always a contiguous run of ones starting at bit 0.
- R3: reset_n is low until all four gates are enabled and gate_full[3] has been sampled high. It rises exactly RST_CYCLES edges after that sampling edge. sysrst_n stays high throughout.
- R4: If any uv_ok bit is sampled low in ON_STEP, RST_WAIT, RUN or OFF_STEP, then on that edge all gate_en bits go low, reset_n goes low and sysrst_n goes low.
- R5: If en_n is sampled high during power-up or run, then on that edge reset_n goes low and the highest enabled gate is disabled. The next lower gate is disabled on the edge that samples gate_low of the gate just disabled.
- R6: If en_n returns low during the turn-off sequence, the sequence still completes. A fresh qualification window then starts, and gate A returns QUAL_CYCLES+1 edges after the edge where channel A's low flag ends the sequence.
- R7: If an on or off step does not receive its feedback within STEP_TIMEOUT edges, the controller enters the fault state on that edge: all gates off, reset_n low, sysrst_n low.
- R8: The fault state holds while en_n is low, even after uv_ok recovers. The edge that samples en_n high returns the controller to idle, with sysrst_n high and all gates off.
- R9: During and right after reset, gate_en is 4'b0000, reset_n is 0 and sysrst_n is 1.
- R10: Losing a uv_ok bit during qualification returns the controller to idle without a fault: sysrst_n stays high and the gates stay off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low sequencing enable |
| uv_ok | input | NCH | Per-rail undervoltage-good flags |
| gate_near | input | NCH | Gate within about 1 V of its full high level |
| gate_full | input | NCH | Gate at its full high level |
| gate_low | input | NCH | Gate below about 0.6 V |
| gate_en | output | NCH | Per-channel gate drive enable, bit 0 = A |
| reset_n | output | 1 | Active-low system-ready reset |
| sysrst_n | output | 1 | Active-low fault reset |

## Verification
Power-up is driven by a gate model whose near, full and low latencies are drawn at random per channel from a fixed seed. This separates advancing on feedback from advancing on fixed time. Each run ends in one of three ways, chosen at random: a clean shutdown, a shutdown with the enable reasserted partway through, or an undervoltage drop while running. Together these tell reverse ordering, run-to-completion and simultaneous fault shutdown apart. Directed cases cover three more situations. Breaking the qualification window shows the difference between a restart and a fault. Freezing all feedback exposes the step timeout at its exact cycle. An undervoltage drop partway through power-up shows that a fault can happen before the run state.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_QUAL     = 3'd1,
        ST_ON_STEP  = 3'd2,
        ST_RST_WAIT = 3'd3,
        ST_RUN      = 3'd4,
        ST_OFF_STEP = 3'd5,
        ST_FAULT    = 3'd6
    } seq_state_t;

endpackage

// File: rtl/rcs_window_cnt.sv
// Cycle window counter: done goes high on the LIMIT-th cycle of continuous run.
module rcs_window_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else if (cnt != LAST_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        done = run && (cnt == LAST_V);
    end
endmodule

// File: rtl/rcs_gate_map.sv
// Decodes controller state and step index into the per-channel gate enables.
module rcs_gate_map
    import rcs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  seq_state_t      state,
    input  logic [IW-1:0]   idx,
    output logic [NCH-1:0]  gate_en
);
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic all_on, rising_set, falling_set;
        always_comb begin
            all_on      = (state == ST_RST_WAIT) || (state == ST_RUN);
            rising_set  = (state == ST_ON_STEP)  && (IW'(k) <= idx);
            falling_set = (state == ST_OFF_STEP) && (IW'(k) <  idx);
            gate_en[k]  = all_on || rising_set || falling_set;
        end
    end
endmodule

// File: rtl/rail_chain_seq.sv
// Four-channel rail sequencer: fixed A..D up, D..A down, stepped by gate feedback.
module rail_chain_seq
    import rcs_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int QUAL_CYCLES  = 1_000_000,
    parameter int RST_CYCLES   = 16_000_000,
    parameter int STEP_TIMEOUT = 100_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_n,
    input  logic [NCH-1:0] uv_ok,
    input  logic [NCH-1:0] gate_near,
    input  logic [NCH-1:0] gate_full,
    input  logic [NCH-1:0] gate_low,
    output logic [NCH-1:0] gate_en,
    output logic           reset_n,
    output logic           sysrst_n
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IW-1:0] IDX_LAST  = IW'(NCH - 1);
    localparam logic [IW-1:0] IDX_FIRST = '0;

    seq_state_t    state, state_nxt;
    logic [IW-1:0] idx, idx_nxt;

    logic uv_all, qual_ok, in_step, step_hit, step_restart;
    logic qual_done, hold_done, step_late;

    // Input qualification terms
    always_comb begin
        uv_all  = &uv_ok;
        qual_ok = uv_all && !en_n;
        in_step = (state == ST_ON_STEP) || (state == ST_OFF_STEP);
    end

    // Feedback for the step currently in progress
    always_comb begin
        step_hit = 1'b0;
        if (state == ST_ON_STEP) begin
            step_hit = (idx == IDX_LAST) ? gate_full[idx] : gate_near[idx];
        end else if (state == ST_OFF_STEP) begin
            step_hit = gate_low[idx];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= IDX_FIRST;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_IDLE: begin
                if (qual_ok) state_nxt = ST_QUAL;
            end
            ST_QUAL: begin
                if (!qual_ok) begin
                    state_nxt = ST_IDLE;
                end else if (qual_done) begin
                    state_nxt = ST_ON_STEP;
                    idx_nxt   = IDX_FIRST;
                end
            end
            ST_ON_STEP: begin
                if (!uv_all) begin
                    state_nxt = ST_FAULT;
                end else if (en_n) begin
                    state_nxt = ST_OFF_STEP;
                end else if (step_hit) begin
                    if (idx == IDX_LAST) state_nxt = ST_RST_WAIT;
                    else                 idx_nxt   = idx + 1'b1;
                end else if (step_late) begin
                    state_nxt = ST_FAULT;
                end
            end
            ST_RST_WAIT: begin
                if (!uv_all) begin
                    state_nxt = ST_FAULT;
                end else if (en_n) begin
                    state_nxt = ST_OFF_STEP;
                    idx_nxt   = IDX_LAST;
                end else if (hold_done) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!uv_all) begin
                    state_nxt = ST_FAULT;
                end else if (en_n) begin
                    state_nxt = ST_OFF_STEP;
                    idx_nxt   = IDX_LAST;
                end
            end
            ST_OFF_STEP: begin
                if (!uv_all) begin
                    state_nxt = ST_FAULT;
                end else if (step_hit) begin
                    if (idx == IDX_FIRST) state_nxt = ST_IDLE;
                    else                  idx_nxt   = idx - 1'b1;
                end else if (step_late) begin
                    state_nxt = ST_FAULT;
                end
            end
            ST_FAULT: begin
                if (en_n) state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
                idx_nxt   = IDX_FIRST;
            end
        endcase
    end

    always_comb begin
        step_restart = (state_nxt != state) || (idx_nxt != idx);
    end

    rcs_window_cnt #(.LIMIT(QUAL_CYCLES)) u_qual_win (
        .clk(clk), .rst_n(rst_n),
        .run(qual_ok && (state == ST_QUAL)), .restart(1'b0),
        .done(qual_done)
    );

    rcs_window_cnt #(.LIMIT(RST_CYCLES)) u_hold_win (
        .clk(clk), .rst_n(rst_n),
        .run(state == ST_RST_WAIT), .restart(1'b0),
        .done(hold_done)
    );

    rcs_window_cnt #(.LIMIT(STEP_TIMEOUT)) u_step_win (
        .clk(clk), .rst_n(rst_n),
        .run(in_step), .restart(step_restart),
        .done(step_late)
    );

    rcs_gate_map #(.NCH(NCH), .IW(IW)) u_gate_map (
        .state(state), .idx(idx), .gate_en(gate_en)
    );

    // Output decode
    always_comb begin
        reset_n  = (state == ST_RUN);
        sysrst_n = (state != ST_FAULT);
    end
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_n,
    input logic [NCH-1:0] uv_ok,
    input logic [NCH-1:0] gate_near,
    input logic [NCH-1:0] gate_en,
    input logic           reset_n,
    input logic           sysrst_n
);
    logic [NCH-1:0] en_plus;
    assign en_plus = gate_en + NCH'(1);

    AST_GATES_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n) (en_plus & gate_en) == '0); // R2

    for (genvar k = 1; k < NCH; k++) begin : g_rise
        AST_RISE_AFTER_NEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_en[k]) |-> $past(gate_near[k-1])); // R2
    end

    AST_READY_NEEDS_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n) reset_n |-> (&gate_en)); // R3

    AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) !sysrst_n |-> ((gate_en == '0) && !reset_n)); // R4

    AST_UV_DROP_TRIPS: assert property (@(posedge clk) disable iff (!rst_n) (reset_n && !(&uv_ok)) |=> !sysrst_n); // R4

    AST_RELEASE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) (reset_n && en_n && (&uv_ok)) |=> (!reset_n && sysrst_n)); // R5
endmodule

bind rail_chain_seq rcs_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_ok(uv_ok),
    .gate_near(gate_near), .gate_en(gate_en),
    .reset_n(reset_n), .sysrst_n(sysrst_n)
);

// File: tb/rail_chain_seq_test.sv
module rail_chain_seq_test;
    localparam int QUAL  = 8;
    localparam int RSTD  = 12;
    localparam int STEPT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic [3:0] uv_ok = 4'h0;
    logic [3:0] gate_near = 4'h0;
    logic [3:0] gate_full = 4'h0;
    logic [3:0] gate_low  = 4'h0;
    logic [3:0] gate_en;
    logic       reset_n, sysrst_n;

    int  nvec = 0;
    int  nfail = 0;
    bit  finished = 0;
    bit  plant_hold = 0;
    int  on_cnt[4], off_cnt[4], dn[4], df[4], dl[4];

    always #5 clk = ~clk;

    rail_chain_seq #(
        .NCH(4), .QUAL_CYCLES(QUAL), .RST_CYCLES(RSTD), .STEP_TIMEOUT(STEPT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_ok(uv_ok),
        .gate_near(gate_near), .gate_full(gate_full), .gate_low(gate_low),
        .gate_en(gate_en), .reset_n(reset_n), .sysrst_n(sysrst_n)
    );

    // Analog gate model: feedback flags follow the enables after per-channel latencies
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (gate_en[k]) begin
                on_cnt[k]    <= on_cnt[k] + 1;
                off_cnt[k]   <= 0;
                gate_near[k] <= !plant_hold && (on_cnt[k] + 1 >= dn[k]);
                gate_full[k] <= !plant_hold && (on_cnt[k] + 1 >= df[k]);
                gate_low[k]  <= 1'b0;
            end else begin
                on_cnt[k]    <= 0;
                off_cnt[k]   <= off_cnt[k] + 1;
                gate_near[k] <= 1'b0;
                gate_full[k] <= 1'b0;
                gate_low[k]  <= !plant_hold && (off_cnt[k] + 1 >= dl[k]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [3:0] m);
        int c = 0;
        for (int i = 0; i < 4; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [3:0] exp_on(input logic [3:0] m, input logic [3:0] nr);
        int t = ones(m);
        if (t > 0 && t < 4 && nr[t-1]) return m | (4'b0001 << t);
        return m;
    endfunction

    function automatic logic [3:0] exp_off(input logic [3:0] m, input logic [3:0] lw);
        int t = ones(m);
        if (t > 0 && t < 4 && lw[t]) return m >> 1;
        return m;
    endfunction

    task automatic randomize_plant();
        for (int k = 0; k < 4; k++) begin
            dn[k] = 1 + int'($urandom % 6);
            df[k] = dn[k] + 1 + int'($urandom % 3);
            dl[k] = 1 + int'($urandom % 6);
        end
    endtask

    task automatic settle();
        en_n  = 1'b1;
        uv_ok = 4'hF;
        repeat (12) tick();
    endtask

    task automatic bring_up();
        logic [3:0] pm, ns, fs;
        int  n = 0;
        int  guard = 0;
        bit  seen = 0;
        randomize_plant();
        en_n  = 1'b0;
        uv_ok = 4'hF;
        repeat (QUAL) tick();
        chk_eq("R1 gates held during window", int'(gate_en), 0);
        tick();
        chk_eq("R1 gate A after window", int'(gate_en), 1);
        while (!(seen && n >= RSTD) && guard < 400) begin
            pm = gate_en; ns = gate_near; fs = gate_full;
            tick();
            guard++;
            if (!seen) begin
                chk_eq("R2 turn-on order", int'(gate_en), int'(exp_on(pm, ns)));
                chk_eq("R3 ready held low", int'(reset_n), 0);
                if (pm == 4'hF && fs[3]) begin
                    seen = 1;
                    n = 0;
                end
            end else begin
                n++;
                chk_eq("R3 ready release timing", int'(reset_n), (n >= RSTD) ? 1 : 0);
                chk_eq("R3 fault reset stays high", int'(sysrst_n), 1);
            end
        end
        if (!(seen && n >= RSTD)) chk_eq("R3 power-up completes", 0, 1);
    endtask

    task automatic shutdown(input bit mid);
        logic [3:0] pm, lw;
        int  guard = 0;
        bit  reen = 0;
        pm = gate_en;
        en_n = 1'b1;
        tick();
        chk_eq("R5 ready low on release", int'(reset_n), 0);
        chk_eq("R5 top gate off first", int'(gate_en), int'(pm >> 1));
        while (guard < 200) begin
            pm = gate_en; lw = gate_low;
            if (mid && !reen) begin
                en_n = 1'b0;
                reen = 1;
            end
            tick();
            guard++;
            if (mid) chk_eq("R6 off sequence continues", int'(gate_en), int'(exp_off(pm, lw)));
            else     chk_eq("R5 reverse turn-off", int'(gate_en), int'(exp_off(pm, lw)));
            if (pm == 4'h0 && lw[0]) break;
        end
        if (mid) begin
            repeat (QUAL) tick();
            chk_eq("R6 fresh window after off", int'(gate_en), 0);
            tick();
            chk_eq("R6 gate A returns", int'(gate_en), 1);
        end
    endtask

    task automatic fault_after_run();
        int b = int'($urandom % 4);
        uv_ok = 4'hF & ~(4'b0001 << b);
        tick();
        chk_eq("R4 gates drop together", int'(gate_en), 0);
        chk_eq("R4 fault reset low", int'(sysrst_n), 0);
        chk_eq("R4 ready low", int'(reset_n), 0);
        uv_ok = 4'hF;
        repeat (5) tick();
        chk_eq("R8 fault holds", int'(sysrst_n), 0);
        chk_eq("R8 gates stay off", int'(gate_en), 0);
        en_n = 1'b1;
        tick();
        chk_eq("R8 fault exit", int'(sysrst_n), 1);
        settle();
    endtask

    task automatic fault_mid_on();
        randomize_plant();
        en_n  = 1'b0;
        uv_ok = 4'hF;
        repeat (QUAL + 1) tick();
        chk_eq("R1 gate A on", int'(gate_en), 1);
        repeat (int'($urandom % 4)) tick();
        uv_ok = 4'hF & ~(4'b0001 << ($urandom % 4));
        tick();
        chk_eq("R4 mid power-up gates off", int'(gate_en), 0);
        chk_eq("R4 mid power-up fault reset", int'(sysrst_n), 0);
        uv_ok = 4'hF;
        en_n  = 1'b1;
        tick();
        chk_eq("R8 fault exit on release", int'(sysrst_n), 1);
        settle();
    endtask

    task automatic step_timeout();
        plant_hold = 1;
        en_n  = 1'b0;
        uv_ok = 4'hF;
        repeat (QUAL + 1) tick();
        chk_eq("R7 gate A on", int'(gate_en), 1);
        repeat (STEPT - 1) tick();
        chk_eq("R7 waiting before timeout", int'(gate_en), 1);
        chk_eq("R7 no fault before timeout", int'(sysrst_n), 1);
        tick();
        chk_eq("R7 timeout gates off", int'(gate_en), 0);
        chk_eq("R7 timeout fault reset", int'(sysrst_n), 0);
        en_n = 1'b1;
        tick();
        plant_hold = 0;
        settle();
    endtask

    task automatic qual_break();
        bit by_en = bit'($urandom % 2);
        en_n  = 1'b0;
        uv_ok = 4'hF;
        repeat (QUAL / 2) tick();
        if (by_en) en_n = 1'b1;
        else       uv_ok = 4'hF & ~(4'b0001 << ($urandom % 4));
        tick();
        chk_eq("R10 no fault on window loss", int'(sysrst_n), 1);
        chk_eq("R10 gates off on window loss", int'(gate_en), 0);
        en_n  = 1'b0;
        uv_ok = 4'hF;
        repeat (QUAL) tick();
        chk_eq("R1 window restarted", int'(gate_en), 0);
        tick();
        chk_eq("R1 gate A after restart", int'(gate_en), 1);
        shutdown(0);
        settle();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        randomize_plant();
        repeat (3) tick();
        chk_eq("R9 reset gates", int'(gate_en), 0);
        chk_eq("R9 reset ready", int'(reset_n), 0);
        chk_eq("R9 reset fault line", int'(sysrst_n), 1);
        rst_n = 1'b1;
        tick();
        chk_eq("R9 after reset gates", int'(gate_en), 0);
        chk_eq("R9 after reset fault line", int'(sysrst_n), 1);
        settle();

        qual_break();
        step_timeout();
        bring_up();
        fault_after_run();
        for (int i = 0; i < 6; i++) begin
            bring_up();
            case ($urandom % 3)
                0: shutdown(0);
                1: begin shutdown(1); shutdown(0); end
                default: fault_after_run();
            endcase
            settle();
        end
        fault_mid_on();
        fault_mid_on();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule